// File: doc/BRIEF.md
# Packetized OTP Read Controller

This block sits between a simple register bus and a one-time-programmable word array. The array holds variable-length packets placed back to back from word 0. Each packet is one header word followed by payload words, and the header states the payload length. Software puts a word address into the mode register and writes the read command. The controller then walks the packet chain from word 0 until it finds the packet whose span contains that address. It copies that packet's header into a header register and its payload into a local buffer. A status bit stays high until the copy is finished.

After the load, software reads the header directly. It reads the payload through a pointer register and a data window. Each read of the window returns the next payload word. Writing the pointer moves it, and writing 0 rewinds it to the first payload word. Any address inside a packet's span returns that whole packet. Software must therefore know the packet layout to reach a particular field. The array model in this project is behavioural, and its contents are computed from the packet index. Programming the array is not part of the block.

Top module: `otp_packet_reader`

## Requirements
- R1: Register offsets are: header 0x20, status 0x0C, payload data 0x24, mode 0x04, payload pointer 0x08, control 0x00. Every other offset reads 0. After reset every register reads 0.
- R2: Bits 31:16 of the mode register hold the requested word address and read back as written. Bits 15:0 of the mode register read 0.
- R3: A write to control with bit 6 set, while idle, starts a load. Control always reads 0. Status bit 6 reads 1 from the clock after the command until the load ends.
- R4: A read command written while a load is running is ignored. The running load completes for the address captured when it started.
- R5: Any word address from a packet's first word up to the word before the next packet's first word loads that packet. The header register then holds that packet's header word, whose bits 15:8 give the payload length in words.
- R6: A load of packet k (numbered from 0) with payload length s keeps status bit 6 high for exactly k+1+s clocks. The controller spends one clock on each header it examines and one clock on each payload word it copies.
- R7: Writing 0 to the payload pointer rewinds it. Each read of the payload data register returns the payload word at the pointer and then advances the pointer, so successive reads return the payload in order.
- R8: The pointer never passes the loaded payload length. Reads there return 0 and leave the pointer unchanged. A pointer write above the length is clamped to the length. The pointer reads back at 0x08.
- R9: A requested address past the last packet, or at or beyond the 2816-word (11 KiB) capacity, loads an all-zero header and no payload. For the default array this load takes NUM_PKT+1 clocks.
- R10: The default array holds NUM_PKT=8 packets. Packet k has payload length (k mod 4)+1 and header {k[15:0], length[7:0], 8'h5A}. Its payload word j is {8'hD0, k[7:0], j[15:0]}. The word after the last packet reads as 0.
- R11: While a load is running, the payload data register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken on the rising edge |
| reg_rd | input | 1 | Register read strobe; only advances the payload pointer |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Read data is combinational. The bench therefore drives each access on a falling edge and samples reg_rdata 1 ns later, before the rising edge that commits the write or advances the pointer. A command written before rising edge P0 shows status busy at the next falling edge. The bench counts the falling-edge samples that show busy, and that count must equal k+1+s, or 9 for an address with no packet. The header and the payload are checked only after the busy count has ended. Each payload read's effect on the pointer becomes visible one clock after the read.

// File: rtl/otprd_pkg.sv
// Package: shared constants, register offsets and sequencer state type for
// the packetized OTP read controller. Assumes a 32-bit data word.
package otprd_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned REG_AW    = 8;
    localparam int unsigned SIZE_W    = 8;
    localparam int unsigned SIZE_LSB  = 8;
    localparam int unsigned CAP_WORDS = (11 * 1024) / (WORD_W / 8);
    localparam int unsigned NUM_PKT   = 8;
    localparam int unsigned SIZE_MOD  = 4;
    localparam int unsigned CMD_BIT   = 6;
    localparam int unsigned BUSY_BIT  = 6;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_MODE  = 8'h04;
    localparam logic [REG_AW-1:0] OFF_PPTR  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_STAT  = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_HDR   = 8'h20;
    localparam logic [REG_AW-1:0] OFF_PDATA = 8'h24;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEEK = 2'd1,
        SQ_FILL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/otprd_fuse_array.sv
// Module: behavioural one-time-programmable word array with a combinational
// read port. Its contents are computed from the packet index: NUM_PKT packets
// sit back to back from word 0, and packet k has payload length
// (k mod SIZE_MOD)+1. Words past the last packet, and past CAP_WORDS, read 0.
// Assumes that NUM_PKT is small, because the lookup unrolls one compare per
// packet.
module otprd_fuse_array
    import otprd_pkg::*;
#(
    parameter int unsigned NUM_PKTS = otprd_pkg::NUM_PKT,
    parameter int unsigned CAPACITY = otprd_pkg::CAP_WORDS,
    parameter int unsigned AW       = otprd_pkg::ADDR_W
) (
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [7:0] HDR_TAG = 8'h5A;
    localparam logic [7:0] PAY_TAG = 8'hD0;

    // Computes the stored word at rd_addr by walking the generated packet layout.
    always_comb begin
        int unsigned base;
        int unsigned a;
        logic [7:0]  sz;
        rd_data = '0;
        base    = 0;
        a       = 32'(rd_addr);
        for (int k = 0; k < int'(NUM_PKTS); k++) begin
            sz = 8'((k % int'(SIZE_MOD)) + 1);
            if (a == base)
                rd_data = {16'(k), sz, HDR_TAG};
            else if (a > base && a <= base + 32'(sz))
                rd_data = {PAY_TAG, 8'(k), 16'(a - base - 1)};
            base = base + 32'(sz) + 1;
        end
        if (a >= CAPACITY)
            rd_data = '0;
    end
endmodule

// File: rtl/otprd_seq.sv
// Module: packet seek and buffer-fill sequencer. On start it captures the
// target address and walks the headers from word 0, one per clock. It stops
// at the packet whose span covers the target, then copies that packet's
// payload words into the buffer, one per clock. An all-zero header, or a walk
// that reaches the capacity, ends the load with an empty header. Assumes that
// the packets in the array end at or before the capacity.
module otprd_seq
    import otprd_pkg::*;
#(
    parameter int unsigned AW       = otprd_pkg::ADDR_W,
    parameter int unsigned SW       = otprd_pkg::SIZE_W,
    parameter int unsigned CAPACITY = otprd_pkg::CAP_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     target,
    output logic [AW-1:0]     fuse_addr,
    input  logic [WORD_W-1:0] fuse_data,
    output logic              busy,
    output logic [WORD_W-1:0] hdr_word,
    output logic [SW-1:0]     pay_count,
    output logic              pay_we,
    output logic [SW-1:0]     pay_idx,
    output logic [WORD_W-1:0] pay_data
);
    localparam int unsigned SPAN_W = AW + 1;

    seq_state_e      state_q;
    logic [AW-1:0]   pos_q;
    logic [AW-1:0]   tgt_q;
    logic [AW-1:0]   fptr_q;
    logic [SW-1:0]   fidx_q;
    logic [SW-1:0]   flen_q;
    logic [SW-1:0]   cur_size;
    logic [SPAN_W-1:0] span_end;
    logic            past_cap;

    // Decodes the header under the walk position and drives the buffer write port.
    always_comb begin
        cur_size  = fuse_data[SIZE_LSB +: SW];
        span_end  = {1'b0, pos_q} + SPAN_W'(cur_size) + SPAN_W'(1);
        past_cap  = {1'b0, pos_q} >= SPAN_W'(CAPACITY);
        fuse_addr = (state_q == SQ_FILL) ? fptr_q : pos_q;
        busy      = (state_q != SQ_IDLE);
        pay_we    = (state_q == SQ_FILL);
        pay_idx   = fidx_q;
        pay_data  = fuse_data;
    end

    // State machine that steps the seek walk and the payload copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            pos_q     <= '0;
            tgt_q     <= '0;
            fptr_q    <= '0;
            fidx_q    <= '0;
            flen_q    <= '0;
            hdr_word  <= '0;
            pay_count <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        tgt_q     <= target;
                        pos_q     <= '0;
                        hdr_word  <= '0;
                        pay_count <= '0;
                        state_q   <= SQ_SEEK;
                    end
                end
                SQ_SEEK: begin
                    if (past_cap || cur_size == '0) begin
                        state_q <= SQ_IDLE;
                    end else if ({1'b0, tgt_q} < span_end) begin
                        hdr_word <= fuse_data;
                        fptr_q   <= pos_q + AW'(1);
                        fidx_q   <= '0;
                        flen_q   <= cur_size;
                        state_q  <= SQ_FILL;
                    end else begin
                        pos_q <= span_end[AW-1:0];
                    end
                end
                SQ_FILL: begin
                    fptr_q <= fptr_q + AW'(1);
                    fidx_q <= fidx_q + SW'(1);
                    if (fidx_q == flen_q - SW'(1)) begin
                        pay_count <= flen_q;
                        state_q   <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/otprd_regs.sv
// Module: register file, payload buffer and payload pointer. It decodes bus
// writes into the start pulse and the register updates, holds the captured
// payload, and returns read data combinationally. A read strobe on the
// payload data window advances the pointer, which stops at the loaded length.
module otprd_regs
    import otprd_pkg::*;
#(
    parameter int unsigned AW  = otprd_pkg::ADDR_W,
    parameter int unsigned SW  = otprd_pkg::SIZE_W,
    parameter int unsigned RAW = otprd_pkg::REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] hdr_word,
    input  logic [SW-1:0]     pay_count,
    input  logic              pay_we,
    input  logic [SW-1:0]     pay_idx,
    input  logic [WORD_W-1:0] pay_data,
    output logic              start,
    output logic [AW-1:0]     target
);
    localparam int unsigned DEPTH = 1 << SW;

    logic [WORD_W-1:0] pay_mem [DEPTH];
    logic [AW-1:0]     mode_q;
    logic [SW-1:0]     ptr_q;
    logic              wr_pptr;
    logic              rd_pdata;

    // Decodes the command and the pointer strobes.
    always_comb begin
        start    = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[CMD_BIT] && !busy;
        wr_pptr  = reg_wr && (reg_addr == OFF_PPTR);
        rd_pdata = reg_rd && (reg_addr == OFF_PDATA);
        target   = mode_q;
    end

    // Captures the payload words that the sequencer copies.
    always_ff @(posedge clk) begin
        if (pay_we)
            pay_mem[pay_idx] <= pay_data;
    end

    // Holds the requested word address from the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (reg_wr && reg_addr == OFF_MODE)
            mode_q <= reg_wdata[WORD_W-1 -: AW];
    end

    // Moves the payload pointer: cleared on start, clamped on write, saturating on read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (start)
            ptr_q <= '0;
        else if (wr_pptr)
            ptr_q <= (reg_wdata > WORD_W'(pay_count)) ? pay_count : reg_wdata[SW-1:0];
        else if (rd_pdata && ptr_q < pay_count)
            ptr_q <= ptr_q + SW'(1);
    end

    // Selects the read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_MODE:  reg_rdata = {mode_q, {(WORD_W - AW){1'b0}}};
            OFF_PPTR:  reg_rdata = WORD_W'(ptr_q);
            OFF_STAT:  reg_rdata[BUSY_BIT] = busy;
            OFF_HDR:   reg_rdata = hdr_word;
            OFF_PDATA: reg_rdata = (ptr_q < pay_count) ? pay_mem[ptr_q] : '0;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_packet_reader.sv
// Module: top of the packetized OTP read controller. It connects the register
// file, the seek/fill sequencer and the behavioural array. Assumes a
// single-cycle register bus with combinational read data.
module otp_packet_reader
    import otprd_pkg::*;
#(
    parameter int unsigned NUM_PKTS = otprd_pkg::NUM_PKT,
    parameter int unsigned CAPACITY = otprd_pkg::CAP_WORDS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [7:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata
);
    logic              start;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] fuse_addr;
    logic [WORD_W-1:0] fuse_data;
    logic              busy;
    logic [WORD_W-1:0] hdr_word;
    logic [SIZE_W-1:0] pay_count;
    logic              pay_we;
    logic [SIZE_W-1:0] pay_idx;
    logic [WORD_W-1:0] pay_data;

    otprd_regs #(.AW(ADDR_W), .SW(SIZE_W), .RAW(REG_AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .hdr_word(hdr_word), .pay_count(pay_count),
        .pay_we(pay_we), .pay_idx(pay_idx), .pay_data(pay_data),
        .start(start), .target(target)
    );

    otprd_seq #(.AW(ADDR_W), .SW(SIZE_W), .CAPACITY(CAPACITY)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .fuse_addr(fuse_addr), .fuse_data(fuse_data), .busy(busy),
        .hdr_word(hdr_word), .pay_count(pay_count), .pay_we(pay_we),
        .pay_idx(pay_idx), .pay_data(pay_data)
    );

    otprd_fuse_array #(.NUM_PKTS(NUM_PKTS), .CAPACITY(CAPACITY), .AW(ADDR_W)) i_fuse (
        .rd_addr(fuse_addr), .rd_data(fuse_data)
    );
endmodule

// File: rtl/otprd_chk.sv
// Module: assertion checker bound to otp_packet_reader. It watches the bus
// ports and the wires between the sequencer and the register file.
module otprd_chk
    import otprd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        busy,
    input logic [31:0] hdr_word,
    input logic [7:0]  pay_count
);
    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CTRL && reg_wdata[CMD_BIT] && !busy) |=> busy);

    // R3
    status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_STAT) |-> (reg_rdata[BUSY_BIT] == busy));

    // R11
    busy_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_addr == OFF_PDATA) |-> (reg_rdata == 32'h0));

    // R5
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pay_count == hdr_word[SIZE_LSB +: SIZE_W]));

    // R9
    empty_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hdr_word == 32'h0) |-> (pay_count == 8'h0));
endmodule

bind otp_packet_reader otprd_chk i_otprd_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .hdr_word(hdr_word), .pay_count(pay_count)
);

// File: tb/test_otp_packet_reader.sv
// Bench: directed scenarios for otp_packet_reader, one task per scenario.
module test_otp_packet_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_PPTR = 8'h08,
                           A_STAT = 8'h0C, A_HDR = 8'h20, A_PDATA = 8'h24;

    otp_packet_reader i_otp_packet_reader (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #5 clk = ~clk;

    // Expected layout, taken from R10.
    function automatic int psize(int k);
        return (k % 4) + 1;
    endfunction

    function automatic int pbase(int k);
        int b = 0;
        for (int i = 0; i < k; i++) b += psize(i) + 1;
        return b;
    endfunction

    function automatic int pkt_of(int a);
        for (int k = 0; k < 8; k++)
            if (a >= pbase(k) && a < pbase(k) + psize(k) + 1) return k;
        return -1;
    endfunction

    function automatic logic [31:0] exp_hdr(int k);
        return {16'(k), 8'(psize(k)), 8'h5A};
    endfunction

    function automatic logic [31:0] exp_pay(int k, int j);
        return {8'hD0, 8'(k), 16'(j)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, logic adv, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = adv;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Issues a load and counts the falling-edge samples with status busy.
    task automatic do_load(int addr, output int cyc);
        bus_wr(A_MODE, {16'(addr), 16'h0});
        bus_wr(A_CTRL, 32'h40);
        reg_addr = A_STAT;
        cyc = 0;
        #1;
        while (reg_rdata[6] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [7:0] offs [6] = '{A_CTRL, A_MODE, A_PPTR, A_STAT, A_HDR, A_PDATA};
        foreach (offs[i]) begin
            bus_rd(offs[i], 1'b0, d);
            chk("R1 reset value", d, 32'h0);
        end
        bus_rd(8'h10, 1'b0, d);
        chk("R1 unmapped offset", d, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        bus_wr(A_MODE, 32'hABCD_1234);
        bus_rd(A_MODE, 1'b0, d);
        chk("R2 mode readback", d, 32'hABCD_0000);
        bus_rd(A_CTRL, 1'b0, d);
        chk("R3 control reads zero", d, 32'h0);
    endtask

    // Loads the packet covering addr, then checks the header, busy time and payload stream.
    task automatic t_load(int addr);
        int cyc;
        int k;
        logic [31:0] d;
        k = pkt_of(addr);
        do_load(addr, cyc);
        chk("R6 busy clocks", 32'(cyc), 32'(k + 1 + psize(k)));
        bus_rd(A_HDR, 1'b0, d);
        chk("R5 header of covering packet", d, exp_hdr(k));
        chk("R5 size field", 32'(d[15:8]), 32'(psize(k)));
        bus_wr(A_PPTR, 32'h0);
        for (int j = 0; j < psize(k); j++) begin
            bus_rd(A_PDATA, 1'b1, d);
            chk("R7 R10 payload word", d, exp_pay(k, j));
        end
        bus_rd(A_PDATA, 1'b1, d);
        chk("R8 read past end", d, 32'h0);
        bus_rd(A_PPTR, 1'b0, d);
        chk("R8 pointer saturates", d, 32'(psize(k)));
    endtask

    task automatic t_rewind();
        logic [31:0] d;
        int cyc;
        do_load(9, cyc);
        bus_wr(A_PPTR, 32'h0);
        bus_rd(A_PDATA, 1'b1, d);
        bus_rd(A_PDATA, 1'b1, d);
        chk("R7 second word", d, exp_pay(3, 1));
        bus_wr(A_PPTR, 32'h0);
        bus_rd(A_PDATA, 1'b0, d);
        chk("R7 rewind to first word", d, exp_pay(3, 0));
        bus_wr(A_PPTR, 32'd200);
        bus_rd(A_PPTR, 1'b0, d);
        chk("R8 pointer write clamped", d, 32'd4);
        bus_wr(A_PPTR, 32'd2);
        bus_rd(A_PDATA, 1'b0, d);
        chk("R7 pointer write selects word", d, exp_pay(3, 2));
    endtask

    task automatic t_past(int addr);
        logic [31:0] d;
        int cyc;
        do_load(addr, cyc);
        chk("R9 empty-load busy clocks", 32'(cyc), 32'd9);
        bus_rd(A_HDR, 1'b0, d);
        chk("R9 zero header", d, 32'h0);
        bus_rd(A_PDATA, 1'b1, d);
        chk("R9 no payload", d, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        int cyc;
        bus_wr(A_MODE, {16'd27, 16'h0});
        bus_wr(A_CTRL, 32'h40);
        bus_rd(A_STAT, 1'b0, d);
        chk("R3 status busy after command", d, 32'h40);
        bus_rd(A_PDATA, 1'b1, d);
        chk("R11 data zero while busy", d, 32'h0);
        bus_wr(A_MODE, 32'h0);
        bus_wr(A_CTRL, 32'h40);
        reg_addr = A_STAT;
        cyc = 0;
        #1;
        while (reg_rdata[6] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
        bus_rd(A_HDR, 1'b0, d);
        chk("R4 command during load ignored", d, exp_hdr(7));
        bus_rd(A_STAT, 1'b0, d);
        chk("R4 idle after load", d, 32'h0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode();
        t_load(0);
        t_load(1);
        t_load(4);
        t_load(8);
        t_load(13);
        t_load(14);
        t_load(27);
        t_rewind();
        t_past(28);
        t_past(3000);
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule